// File: doc/BRIEF.md
# Single-Channel Prescaled PWM Timer

This block generates one pulse-width-modulated output from the reference clock. The reference clock is first divided by a coded prescaler whose divisors are not powers of two. The divided ticks then drive a period counter. For each period the output sits at its active level for a programmed number of ticks and at its inactive level for the rest of the period. Software sets the block up through two 32-bit registers: a control word and a period word.

The output can repeat the period without end, or it can emit one period for each start trigger. The active level is selectable. In bypass mode the output follows the reference clock directly. A period write first goes to a shadow copy, so a running waveform never shows a period that mixes old and new values. A read-only busy flag stays high until the staged value has been transferred. The register port takes one request per cycle: `req_ready` is always high, so a request is never back-pressured. Each read returns its data on `rsp_valid` exactly one cycle after it is accepted. The port has no response back-pressure, so the requester must take the data in that cycle.

Top module: `pwm_timer`

## Requirements
- R1: A request with `req_valid` high is always accepted. The control word is at byte offset 0x0 and the period word is at 0x4. A read returns data one cycle later on `rsp_rdata`, with `rsp_valid` high. Any other offset reads 0 and ignores writes. Control layout: [3:0] divider code, bit 4 enable, bit 5 polarity, bit 6 gate, bit 7 one-shot mode, bit 8 start, bit 9 bypass, bit 28 busy (read-only). All other bits read 0. Period layout: [31:16] total ticks minus one, [15:0] active ticks. After reset both words read 0 and `pwm_out` is 1.
- R2: The divider codes map to these tick divisors: 15→1, 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000.
- R3: The waveform runs only while both enable (bit 4) and gate (bit 6) are 1. Otherwise `pwm_out` holds the inactive level and the period restarts from tick 0 when the waveform is next allowed to run.
- R4: With polarity 1 the active level is high and the inactive level is low. With polarity 0 both levels are inverted.
- R5: A period lasts total+1 ticks. The output is active during tick indices below the active count. An active count above total keeps the output active for the whole period. An active count of 0 keeps it inactive.
- R6: With bit 7 at 0 the periods repeat back to back. Tick index 0 starts in the cycle after the enabling write.
- R7: With bit 7 at 1 the block emits exactly one period while start (bit 8) is 1. After that period the output goes inactive and start reads back 0. While start is 0 nothing runs.
- R8: With bypass (bit 9), enable and gate all set, `pwm_out` equals the reference clock when polarity is 1 and its inverse when polarity is 0.
- R9: Divider codes 5, 6, 7, 13 and 14 stop the counter and hold `pwm_out` at the inactive level.
- R10: A period write sets busy and takes effect only at the next period end, or at the next cycle if the waveform is not running. Busy clears at that transfer. A period write that lands in the same cycle as a period end wins: busy stays set, and the newest value applies at the following period end. Reads of the period word return the last written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Always 1; every request is accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pwm_out | output | 1 | PWM output |

## Verification
Two functions can fall in the same cycle: a software write to the period word, and the shadow-to-live transfer at the end of a period. The bench provokes this by running a short period and timing a period write so that it is accepted on the exact edge where the count wraps. It then judges the outcome in two ways. Busy must still read 1 afterwards. The output must keep the intermediate period for one more full period before the newest values appear. In the same run the bench also checks the normal case, where a write lands mid-period and switches at the next wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = REG_W / 2;
  localparam int PRE_W  = 17;
  localparam int CTRL_W = 10;
  localparam int BUSY_BIT = 28;
  localparam int OFS_CTRL = 0;
  localparam int OFS_PER  = 4;

  // Field order matches the control word, MSB first.
  typedef struct packed {
    logic       bypass;
    logic       start;
    logic       one_shot;
    logic       gate;
    logic       pol;
    logic       en;
    logic [3:0] code;
  } ctrl_t;

  // Tick divisor for a divider code; zero marks a reserved code.
  function automatic logic [PRE_W-1:0] div_of(input logic [3:0] code);
    logic [PRE_W-1:0] d;
    case (code)
      4'd0:    d = 17'd120;
      4'd1:    d = 17'd180;
      4'd2:    d = 17'd240;
      4'd3:    d = 17'd360;
      4'd4:    d = 17'd480;
      4'd8:    d = 17'd12000;
      4'd9:    d = 17'd24000;
      4'd10:   d = 17'd36000;
      4'd11:   d = 17'd48000;
      4'd12:   d = 17'd72000;
      4'd15:   d = 17'd1;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  // >= keeps the divider sane if the code shrinks mid-count.
  assign tick = run && (pre_q >= div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_q <= '0;
    else if (!run || tick) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] active,
  output logic             wrap,
  output logic             act
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = run && tick && (cnt_q >= total);
  assign act  = run && (cnt_q < active);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R5: the count never passes the live total while running
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= total));
  // R3: a stopped waveform restarts from tick zero
  p_idle_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic              boundary,
  input  logic              pulse_done,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  live_total,
  output logic [CNT_W-1:0]  live_active,
  output logic              busy_q,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER);
  localparam int GAP_HI = REG_W - 1 - BUSY_BIT;
  localparam int GAP_LO = BUSY_BIT - CTRL_W;

  logic sel_ctrl, sel_per, ctrl_wr, per_wr, rd;
  logic [CNT_W-1:0] sh_total, sh_active;
  logic [REG_W-1:0] ctrl_word;
  logic unused_wbits;

  assign sel_ctrl = (req_addr == A_CTRL);
  assign sel_per  = (req_addr == A_PER);
  assign ctrl_wr  = req_valid && req_write && sel_ctrl;
  assign per_wr   = req_valid && req_write && sel_per;
  assign rd       = req_valid && !req_write;
  assign ctrl_word = {{GAP_HI{1'b0}}, busy_q, {GAP_LO{1'b0}}, ctrl_q};
  assign unused_wbits = ^req_wdata[REG_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (ctrl_wr)    ctrl_q <= ctrl_t'(req_wdata[CTRL_W-1:0]);
    else if (pulse_done) ctrl_q.start <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_total    <= '0;
      sh_active   <= '0;
      live_total  <= '0;
      live_active <= '0;
      busy_q      <= 1'b0;
    end else if (per_wr) begin
      sh_total  <= req_wdata[REG_W-1:CNT_W];
      sh_active <= req_wdata[CNT_W-1:0];
      busy_q    <= 1'b1;
    end else if (busy_q && boundary) begin
      live_total  <= sh_total;
      live_active <= sh_active;
      busy_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= sel_ctrl ? ctrl_word :
                           sel_per  ? {sh_total, sh_active} : '0;
    end
  end

  // R10: a period write always leaves busy set
  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> busy_q);
  // R10: an uncontested boundary completes the transfer
  p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && boundary && !per_wr) |=> !busy_q);
  // R7: the start bit clears itself after the single period
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && !ctrl_wr) |=> !ctrl_q.start);
  // R1: every read is answered in the next cycle
  p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              pwm_out
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] live_total, live_active;
  logic [PRE_W-1:0] div;
  logic busy, code_ok, allowed, run, tick, wrap, act, bypass_on;

  assign req_ready = 1'b1;
  assign div       = div_of(ctrl.code);
  assign code_ok   = (div != '0);
  assign allowed   = ctrl.en && ctrl.gate;
  assign run       = allowed && code_ok && !ctrl.bypass &&
                     (!ctrl.one_shot || ctrl.start);
  assign bypass_on = allowed && ctrl.bypass;

  pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .boundary   (!run || wrap),
    .pulse_done (wrap && ctrl.one_shot),
    .ctrl_q     (ctrl),
    .live_total (live_total),
    .live_active(live_active),
    .busy_q     (busy),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  pwm_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .tick (tick)
  );

  pwm_core u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .total (live_total),
    .active(live_active),
    .wrap  (wrap),
    .act   (act)
  );

  always_comb begin
    if (bypass_on) pwm_out = clk ^ ~ctrl.pol;
    else           pwm_out = act ? ctrl.pol : ~ctrl.pol;
  end

  // R9: a reserved divider code keeps the output inactive
  p_reserved_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed && !ctrl.bypass && !code_ok) |-> (pwm_out == !ctrl.pol));
  // R3: without both enable and gate no tick is produced
  p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !allowed |-> !tick);
endmodule

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, req_valid, req_ready, req_write, rsp_valid, pwm_out;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata;

  always #4 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  int n_chk = 0, n_bad = 0;
  bit mon_on = 0;
  int mon_k = 0;
  string mon_tag = "";
  bit e_pol, e_pulse, e_force;
  int e_div = 1;
  int e_T[3], e_A[3], e_base[3];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_out(int k);
    int s, rel, c;
    if (e_force) return !e_pol;
    s = 0;
    if (k >= e_base[1]) s = 1;
    if (k >= e_base[2]) s = 2;
    if (e_pulse && ((k - e_base[0]) / e_div) > e_T[0]) return !e_pol;
    rel = k - e_base[s];
    c = (rel / e_div) % (e_T[s] + 1);
    return (c < e_A[s]) ? e_pol : !e_pol;
  endfunction

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      check(mon_tag, {31'd0, pwm_out}, {31'd0, exp_out(mon_k)});
      mon_k++;
    end
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_k(int n);
    while (mon_k < n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_w(bit bypass, bit start, bit one_shot,
                                         bit gate, bit pol, bit en, int code);
    return {22'd0, bypass, start, one_shot, gate, pol, en, code[3:0]};
  endfunction

  task automatic run_cfg(int T, int A, bit pol, bit pulse, int code, int div,
                         bit force_idle, int cycles, string tag);
    bus_write(4'h0, 32'd0);
    bus_write(4'h4, {T[15:0], A[15:0]});
    e_pol = pol; e_pulse = pulse; e_force = force_idle; e_div = div;
    e_T[0] = T; e_A[0] = A; e_base[0] = 0; e_base[1] = 1 << 30; e_base[2] = 1 << 30;
    bus_write(4'h0, ctrl_w(0, pulse, pulse, 1, pol, 1, code));
    mon_tag = tag; mon_k = 0; mon_on = 1;
    repeat (cycles) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired before the run finished");
    report();
  end

  initial begin
    logic [31:0] rd;
    int divs[7];
    int codes[7];
    int resv[5];
    codes = '{0, 1, 2, 3, 4, 8, 9};
    divs  = '{120, 180, 240, 360, 480, 12000, 24000};
    resv  = '{5, 6, 7, 13, 14};
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 reset pwm_out", {31'd0, pwm_out}, 32'd1);
    bus_read(4'h0, rd); check("R1 reset ctrl", rd, 32'd0);
    bus_read(4'h4, rd); check("R1 reset period", rd, 32'd0);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, rd); check("R1 unmapped offset", rd, 32'd0);
    bus_write(4'h0, 32'hFFFF_F2A5);
    bus_read(4'h0, rd); check("R1 ctrl readback masks", rd, 32'h0000_02A5);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    bus_write(4'h0, 32'd0);

    // R10: transfer while idle is immediate
    bus_write(4'h4, 32'h0003_0002);
    bus_read(4'h0, rd); check("R10 busy after idle write", {31'd0, rd[28]}, 32'd1);
    bus_read(4'h0, rd); check("R10 busy clears when idle", {31'd0, rd[28]}, 32'd0);
    bus_read(4'h4, rd); check("R1 period readback", rd, 32'h0003_0002);

    // R4 R5 R6 R7: sweep of total, active and polarity in both modes
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 6; a++) begin
          run_cfg(t, a, p[0], 0, 15, 1, 0, 2 * (t + 1) + 1, "R4/R5/R6 cycle mode");
          run_cfg(t, a, p[0], 1, 15, 1, 0, 2 * (t + 1) + 2, "R5/R7 one-shot");
          bus_read(4'h0, rd);
          check("R7 start self-clears", {31'd0, rd[8]}, 32'd0);
        end

    // R7: one-shot with start low never runs
    bus_write(4'h0, 32'd0);
    bus_write(4'h4, 32'h0002_0002);
    e_pol = 1; e_force = 1; e_pulse = 1;
    bus_write(4'h0, ctrl_w(0, 0, 1, 1, 1, 1, 15));
    mon_tag = "R7 idle without start"; mon_k = 0; mon_on = 1;
    repeat (8) @(negedge clk);
    mon_on = 0;

    // R3: enable or gate alone
    bus_write(4'h0, ctrl_w(0, 0, 0, 0, 1, 1, 15));
    mon_tag = "R3 enable without gate"; mon_k = 0; mon_on = 1;
    repeat (8) @(negedge clk);
    bus_write(4'h0, ctrl_w(0, 0, 0, 1, 1, 0, 15));
    mon_tag = "R3 gate without enable";
    repeat (8) @(negedge clk);
    mon_on = 0;

    // R9: reserved codes
    foreach (resv[i]) run_cfg(2, 2, 1, 0, resv[i], 1, 1, 12, "R9 reserved code");

    // R8: bypass follows the clock
    for (int p = 0; p < 2; p++) begin
      bus_write(4'h0, ctrl_w(1, 0, 0, 1, p[0], 1, 0));
      check("R8 bypass low phase", {31'd0, pwm_out}, {31'd0, !p[0]});
      @(posedge clk); #1;
      check("R8 bypass high phase", {31'd0, pwm_out}, {31'd0, p[0]});
      @(negedge clk);
    end
    bus_write(4'h0, ctrl_w(1, 0, 0, 1, 1, 0, 0));
    check("R8 bypass gated off low", {31'd0, pwm_out}, 32'd0);
    @(posedge clk); #1;
    check("R8 bypass gated off high", {31'd0, pwm_out}, 32'd0);
    @(negedge clk);

    // R10: staged update, and a write landing on a period end
    bus_write(4'h0, 32'd0);
    bus_write(4'h4, {16'd9, 16'd3});
    e_pol = 1; e_pulse = 0; e_force = 0; e_div = 1;
    e_T = '{9, 3, 5}; e_A = '{3, 1, 4}; e_base = '{0, 10, 18};
    bus_write(4'h0, ctrl_w(0, 0, 0, 1, 1, 1, 15));
    mon_tag = "R10 staged period"; mon_k = 0; mon_on = 1;
    wait_k(2);
    bus_write(4'h4, {16'd3, 16'd1});
    bus_read(4'h0, rd); check("R10 busy while pending", {31'd0, rd[28]}, 32'd1);
    bus_read(4'h4, rd); check("R10 shadow readback", rd, {16'd3, 16'd1});
    wait_k(11);
    bus_read(4'h0, rd); check("R10 busy clears at period end", {31'd0, rd[28]}, 32'd0);
    wait_k(13);
    bus_write(4'h4, {16'd5, 16'd4});
    bus_read(4'h0, rd); check("R10 write on boundary keeps busy", {31'd0, rd[28]}, 32'd1);
    wait_k(20);
    bus_read(4'h0, rd); check("R10 busy clears next boundary", {31'd0, rd[28]}, 32'd0);
    wait_k(32);
    mon_on = 0;

    // R2: each divider code stretches the tick
    foreach (codes[i])
      run_cfg(1, 1, 1, 0, codes[i], divs[i], 0, 2 * divs[i] + 2, "R2 divider code");

    report();
  end
endmodule